// File: doc/BRIEF.md
# Resonant Link Switch Sequencer

This block drives the four auxiliary switches of a parallel resonant DC link that feeds a four-leg inverter: a charging switch that builds up inductor current, two series link switches and a clamp switch that holds the link at zero volts. It watches the 4-bit word of upper-leg gate commands. When that word changes to a zero vector (all ones or all zeros), it runs one resonant cycle, so that the inverter legs can change state while the link voltage is zero.

A cycle walks through six modes in a fixed order: charge, swing, clamp, refill, restore and settle. The length of each mode is a tick count supplied on an input port. The block captures all six counts at the trigger. The counts come from an outside controller that knows the load current and the supply. This block only sequences the gates and flags a trigger that arrives too early.

Top module: `rlink_seq`

## Requirements
- R1: A cycle starts only in a clock cycle where `up_gates` differs from its value in the previous cycle and is 4'b0000 or 4'b1111. A word that is held, any other word, and the first cycle after reset start nothing.
- R2: While idle (including after reset): `chg_gate`=0, `ser_a_gate`=1, `ser_b_gate`=1, `clamp_gate`=0.
- R3: Mode 1 (charge) begins in the cycle after the trigger. Its gates are `chg_gate`=1 with both series gates on and the clamp off.
- R4: Mode 2 (swing) turns `ser_a_gate` off. `chg_gate` and `ser_b_gate` stay on.
- R5: Mode 3 (clamp) turns `ser_b_gate` off and `clamp_gate` on. The clamp is never on while either series gate is on.
- R6: Mode 4 (refill) turns `clamp_gate` off and `ser_b_gate` back on. `ser_a_gate` stays off and `chg_gate` stays on.
- R7: Mode 5 (restore) turns `ser_a_gate` back on with `chg_gate` still on. Mode 6 (settle) drives the idle gate pattern with `chg_gate` off. The block then returns to idle.
- R8: Mode k lasts `phase_len[k-1]` cycles (index 0 belongs to charge, index 5 to settle). A count of 0 lasts one cycle. All six counts are captured at the trigger, so later changes on `phase_len` do not affect a running cycle.
- R9: A trigger that occurs while busy is ignored and the running cycle continues unchanged. It sets `overrun`, which stays set until reset.
- R10: `busy` is high from the cycle after an accepted trigger until idle is re-entered. A cycle therefore keeps `busy` high for the sum of the six effective mode lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_gates | input | 4 | Upper-leg gate command word of the inverter |
| phase_len | input | 6 x DUR_W | Mode lengths in ticks, index 0 is mode 1 |
| chg_gate | output | 1 | Charging switch gate |
| ser_a_gate | output | 1 | First series link switch gate |
| ser_b_gate | output | 1 | Second series link switch gate |
| clamp_gate | output | 1 | Clamp switch gate |
| busy | output | 1 | Resonant cycle in progress |
| overrun | output | 1 | Sticky early-trigger fault |

## Verification
The assertions check several rules on every cycle. The idle gate pattern must match the busy flag. The clamp must never overlap a series gate. Each series gate may only fall or return in its allowed neighbour mode. The overrun flag must stay sticky, and a trigger while busy must raise it. Only the bench scenarios can show the exact length of each mode. The same goes for zero counts stretching to one tick and for lengths captured at the trigger surviving later input changes. They also show that held or non-zero-vector words never start a cycle, and that an early trigger does not restart one. The reference model in the bench follows every gate on every clock through these scenarios.

// File: rtl/rlink_pkg.sv
package rlink_pkg;

    localparam int N_PHASE = 6;
    localparam int PH_IDX_W = $clog2(N_PHASE);

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_CHARGE  = 3'd1,
        PH_SWING   = 3'd2,
        PH_CLAMP   = 3'd3,
        PH_REFILL  = 3'd4,
        PH_RESTORE = 3'd5,
        PH_SETTLE  = 3'd6
    } phase_e;

    typedef struct packed {
        logic chg;
        logic ser_a;
        logic ser_b;
        logic clamp;
    } gates_t;

    // Gate pattern owned by each mode of the resonant cycle.
    function automatic gates_t phase_gates(phase_e p);
        gates_t g;
        g.chg   = (p == PH_CHARGE) || (p == PH_SWING) || (p == PH_CLAMP) ||
                  (p == PH_REFILL) || (p == PH_RESTORE);
        g.ser_a = (p == PH_IDLE) || (p == PH_CHARGE) || (p == PH_RESTORE) ||
                  (p == PH_SETTLE);
        g.ser_b = (p != PH_CLAMP);
        g.clamp = (p == PH_CLAMP);
        return g;
    endfunction

endpackage

// File: rtl/rlink_trig.sv
module rlink_trig #(
    parameter int LEGS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LEGS-1:0] word,
    output logic            fire
);
    logic [LEGS-1:0] prev_q;
    logic            prev_vld_q;
    logic            is_zero_vec;

    assign is_zero_vec = (&word) || (~|word);
    assign fire        = prev_vld_q && is_zero_vec && (word != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= '0;
            prev_vld_q <= 1'b0;
        end else begin
            prev_q     <= word;
            prev_vld_q <= 1'b1;
        end
    end

    // A word held steady never fires twice (R1).
    p_held_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (prev_vld_q && $stable(word)) |-> !fire);
endmodule

// File: rtl/rlink_timer.sv
module rlink_timer #(
    parameter int DUR_W = 8,
    parameter int NPH   = 6,
    localparam int IDX_W = $clog2(NPH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_all,
    input  logic                      step,
    input  logic [IDX_W-1:0]          nxt_idx,
    input  logic [NPH-1:0][DUR_W-1:0] dur_in,
    output logic                      expired
);
    logic [NPH-1:0][DUR_W-1:0] lat_q;
    logic [DUR_W-1:0]          cnt_q;

    // Remaining extra ticks after the first; zero is stretched to one tick.
    function automatic logic [DUR_W-1:0] reload(logic [DUR_W-1:0] d);
        return (d == '0) ? '0 : d - 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            cnt_q <= '0;
        end else if (load_all) begin
            lat_q <= dur_in;
            cnt_q <= reload(dur_in[0]);
        end else if (step) begin
            cnt_q <= reload(lat_q[nxt_idx]);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // Captured lengths only change at a new load (R8).
    p_lat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(load_all) |-> $stable(lat_q));
endmodule

// File: rtl/rlink_seq.sv
module rlink_seq
    import rlink_pkg::*;
#(
    parameter int DUR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [3:0]                    up_gates,
    input  logic [N_PHASE-1:0][DUR_W-1:0] phase_len,
    output logic                          chg_gate,
    output logic                          ser_a_gate,
    output logic                          ser_b_gate,
    output logic                          clamp_gate,
    output logic                          busy,
    output logic                          overrun
);
    phase_e  state_q;
    logic    fire;
    logic    expired;
    logic    accept;
    logic    step;
    logic    fault_q;
    gates_t  g;
    logic [PH_IDX_W-1:0] nxt_idx;

    rlink_trig #(.LEGS(4)) u_trig (
        .clk  (clk),
        .rst  (rst),
        .word (up_gates),
        .fire (fire)
    );

    assign accept  = fire && (state_q == PH_IDLE);
    assign step    = (state_q != PH_IDLE) && (state_q != PH_SETTLE) && expired;
    assign nxt_idx = state_q;

    rlink_timer #(.DUR_W(DUR_W), .NPH(N_PHASE)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_all (accept),
        .step     (step),
        .nxt_idx  (nxt_idx),
        .dur_in   (phase_len),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            fault_q <= 1'b0;
        end else begin
            if (accept) begin
                state_q <= PH_CHARGE;
            end else if (state_q != PH_IDLE && expired) begin
                state_q <= (state_q == PH_SETTLE) ? PH_IDLE
                                                  : phase_e'(state_q + 3'd1);
            end
            if (fire && state_q != PH_IDLE) fault_q <= 1'b1;
        end
    end

    assign g          = phase_gates(state_q);
    assign chg_gate   = g.chg;
    assign ser_a_gate = g.ser_a;
    assign ser_b_gate = g.ser_b;
    assign clamp_gate = g.clamp;
    assign busy       = (state_q != PH_IDLE);
    assign overrun    = fault_q;

    p_idle_gates_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!chg_gate && ser_a_gate && ser_b_gate && !clamp_gate));
    p_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && !busy) |=> (busy && chg_gate && ser_a_gate && ser_b_gate));
    p_sa_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_a_gate) |-> (chg_gate && ser_b_gate && !clamp_gate));
    p_clamp_excl_r5: assert property (@(posedge clk) disable iff (rst)
        clamp_gate |-> (!ser_a_gate && !ser_b_gate && chg_gate));
    p_sb_return_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(clamp_gate) |-> (ser_b_gate && !ser_a_gate && chg_gate));
    p_chg_drop_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(chg_gate) |-> ($past(ser_a_gate) && ser_a_gate && ser_b_gate));
    p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (fire && busy) |=> (overrun && busy));
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
    p_busy_end_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(busy) && !$past(chg_gate) && $past(ser_a_gate)));
endmodule

// File: tb/rlink_seq_bench.sv
`timescale 1ns/1ps
module rlink_seq_bench;
    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       up_gates = 4'b0101;
    logic [5:0][7:0]  phase_len = '0;
    logic chg_gate, ser_a_gate, ser_b_gate, clamp_gate, busy, overrun;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rlink_seq #(.DUR_W(8)) u_rlink_seq (
        .clk(clk), .rst(rst), .up_gates(up_gates), .phase_len(phase_len),
        .chg_gate(chg_gate), .ser_a_gate(ser_a_gate), .ser_b_gate(ser_b_gate),
        .clamp_gate(clamp_gate), .busy(busy), .overrun(overrun)
    );

    // Behavioural reference: mode number 0..6, ticks left in mode.
    int       m_mode = 0;
    int       m_left = 0;
    int       m_lat [6];
    logic [3:0] m_prev = 4'b0;
    bit       m_pv = 1'b0;
    bit       m_fault = 1'b0;
    bit       m_t;

    function automatic int eff(int d);
        return (d == 0) ? 1 : d;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_left = 0; m_pv = 1'b0; m_fault = 1'b0;
        end else begin
            m_t = m_pv && (up_gates == 4'hF || up_gates == 4'h0) && (up_gates != m_prev);
            if (m_mode == 0) begin
                if (m_t) begin
                    for (int i = 0; i < 6; i++) m_lat[i] = int'(phase_len[i]);
                    m_mode = 1;
                    m_left = eff(m_lat[0]);
                end
            end else begin
                if (m_t) m_fault = 1'b1;
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_mode == 6) m_mode = 0;
                    else begin
                        m_mode = m_mode + 1;
                        m_left = eff(m_lat[m_mode-1]);
                    end
                end
            end
            m_prev = up_gates;
            m_pv   = 1'b1;
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the reference.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(chg_gate,   (m_mode >= 1 && m_mode <= 5), m_mode == 0 ? "R2 chg" : "R3 R7 chg");
            check(ser_a_gate, (m_mode == 0 || m_mode == 1 || m_mode == 5 || m_mode == 6),
                  m_mode == 0 ? "R2 ser_a" : "R4 R7 ser_a");
            check(ser_b_gate, (m_mode != 3), m_mode == 0 ? "R2 ser_b" : "R5 R6 ser_b");
            check(clamp_gate, (m_mode == 3), "R5 clamp");
            check(busy,       (m_mode != 0), "R10 busy");
            check(overrun,    m_fault, "R9 overrun");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count busy cycles after a trigger driven at the current negedge.
    task automatic run_len(input int exp, input bool_mess, input string tag);
        int n = 0;
        tick(1);
        while (busy) begin
            n++;
            if (bool_mess && n == 2) phase_len = {6{8'd9}};
            tick(1);
        end
        check_int(n, exp, tag);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);
        check(busy, 1'b0, "R2 reset busy");
        check(overrun, 1'b0, "R2 reset overrun");
        check(ser_a_gate & ser_b_gate & ~chg_gate & ~clamp_gate, 1'b1, "R2 reset gates");

        // Main cycle, lengths changed mid-cycle must not matter.
        phase_len = {8'd2, 8'd3, 8'd2, 8'd4, 8'd2, 8'd3};
        up_gates  = 4'b0000;
        run_len(16, 1'b1, "R8 R10 captured lengths");

        // Held zero vector must not retrigger.
        tick(6);
        check(busy, 1'b0, "R1 held word");

        // Non-zero vectors start nothing.
        up_gates = 4'b0011; tick(1);
        up_gates = 4'b1000; tick(1);
        up_gates = 4'b0111; tick(3);
        check(busy, 1'b0, "R1 active vectors");

        // Zero counts stretch to one tick.
        phase_len = {8'd0, 8'd2, 8'd0, 8'd1, 8'd0, 8'd0};
        up_gates  = 4'b1111;
        run_len(7, 1'b0, "R8 zero lengths");

        // Early triggers during a cycle.
        phase_len = {6{8'd3}};
        up_gates  = 4'b0000;
        tick(4);
        up_gates = 4'b0001; tick(1);
        up_gates = 4'b1111; tick(1);
        check(overrun, 1'b1, "R9 overrun set");
        begin
            int n = 5;
            while (busy) begin n++; tick(1); end
            check_int(n, 18, "R9 early trigger ignored");
        end
        tick(4);
        check(overrun, 1'b1, "R9 overrun sticky");

        // Trigger straight after returning idle.
        up_gates  = 4'b0000;
        phase_len = {8'd1, 8'd1, 8'd2, 8'd1, 8'd1, 8'd1};
        run_len(7, 1'b0, "R3 R10 back to back");

        rst = 1'b1; tick(2);
        rst = 1'b0; tick(2);
        check(overrun, 1'b0, "R9 reset clears");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule